// File: doc/BRIEF.md
# Graphics Mask and Color Register Loader

This block sits on the device side of a graphics DRAM command interface. On every clock it decodes the chip select, row strobe, column strobe and write enable lines, together with a special-function qualifier. When the qualifier is low, the four command lines mean what they mean on an ordinary SDRAM. The block then raises a one-cycle strobe for activate, write, refresh or mode set.

When the qualifier is high, the same encodings select graphics variants:

- Activate becomes activate with write-per-bit.
- Write becomes block write.
- Refresh becomes the special refresh variant.
- Mode set becomes a special register load.

The special register load writes a write-per-bit mask register, a color register, or both, from the DQ bus.

A load of only one register takes the DQ word that comes with the command. A load of both registers takes two DQ words in a row: the mask word with the command, then the color word on the next cycle. During that second cycle the block reports busy. Any command other than a NOP in that cycle is flagged as illegal and has no effect. Banks, the array and the masking of array data are handled elsewhere.

Top module: `gfx_special_reg_loader`

## Requirements
- R1: After reset, the mask register and the color register are both zero, and busy is low.
- R2: A special load has all four command lines low, the qualifier high and the mask select high with the color select low. It stores DQ into the mask register on that clock edge, one bit per DQ line, and leaves the color register unchanged.
- R3: A special load with the color select high and the mask select low stores DQ into the color register on that edge and leaves the mask register unchanged.
- R4: A special load with both selects high does three things:
  - It stores that cycle's DQ into the mask register.
  - It stores the next cycle's DQ into the color register.
  - It holds busy high for exactly that next cycle.
- R5: All four command lines low with the qualifier low is a normal mode set. It raises the mode-set strobe and leaves both registers unchanged.
- R6: With the qualifier high, three encodings give the graphics strobes:
  - chip select, row strobe, column strobe, write enable = 0,0,1,1 raises activate-with-write-per-bit;
  - 0,1,0,0 raises block write;
  - 0,0,0,1 raises special refresh.
- R7: With the qualifier low, the same three encodings raise the plain activate, write and refresh strobes instead. At most one strobe is high in any cycle.
- R8: While busy is high, any command that is not a NOP raises the illegal flag. In that cycle every command strobe stays low and no new load starts, even if the command is itself a special load. A command on the following cycle is accepted normally.
- R9: A special load with neither select high leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function qualifier |
| selMask | input | 1 | Mask register select for a special load |
| selColor | input | 1 | Color register select for a special load |
| dq | input | DQ_W | Data bus |
| maskReg | output | DQ_W | Write-per-bit mask register |
| colorReg | output | DQ_W | Color register |
| busy | output | 1 | Second data cycle of a combined load |
| illegal | output | 1 | Non-NOP command seen while busy |
| actStb | output | 1 | Plain activate |
| actWpbStb | output | 1 | Activate with write-per-bit |
| wrStb | output | 1 | Plain write |
| blockWrStb | output | 1 | Block write |
| refStb | output | 1 | Plain refresh |
| specRefStb | output | 1 | Special refresh |
| modeSetStb | output | 1 | Normal mode set |

## Verification
The bench builds the block with the default DQ_W of 32, so the registers are as wide as the data bus. With random 32-bit DQ words every bit line gets loaded in both registers, and the all-ones and all-zero words reach the extremes of the range. Random bursts of command encodings often land a special load, or some other command, in the busy cycle of a combined load. The bench also places back-to-back combined loads on purpose.

// File: rtl/gfx_smrs_pkg.sv
package gfx_smrs_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_WRITE,
    CMD_REFRESH,
    CMD_MODESET,
    CMD_OTHER
  } cmdKind_e;

  typedef struct packed {
    logic loadMask;
    logic loadColor;
  } loadStrobe_t;

  function automatic cmdKind_e decodeCmd(input logic csN, input logic rasN,
                                         input logic casN, input logic weN);
    cmdKind_e k;
    if (csN) k = CMD_NOP;
    else begin
      case ({rasN, casN, weN})
        3'b111:  k = CMD_NOP;
        3'b011:  k = CMD_ACT;
        3'b100:  k = CMD_WRITE;
        3'b001:  k = CMD_REFRESH;
        3'b000:  k = CMD_MODESET;
        default: k = CMD_OTHER;
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/gfx_cmd_ctrl.sv
module gfx_cmd_ctrl
  import gfx_smrs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic        dsf,
  input  logic        selMask,
  input  logic        selColor,
  output loadStrobe_t load,
  output logic        busy,
  output logic        illegal,
  output logic        actStb,
  output logic        actWpbStb,
  output logic        wrStb,
  output logic        blockWrStb,
  output logic        refStb,
  output logic        specRefStb,
  output logic        modeSetStb
);

  cmdKind_e cmd;
  logic     pendColor;
  logic     accept;
  logic     specLoad;

  always_comb begin
    cmd      = decodeCmd(csN, rasN, casN, weN);
    accept   = !pendColor;
    specLoad = accept && (cmd == CMD_MODESET) && dsf;

    load.loadMask  = specLoad && selMask;
    load.loadColor = (specLoad && selColor && !selMask) || pendColor;

    actStb     = accept && (cmd == CMD_ACT)     && !dsf;
    actWpbStb  = accept && (cmd == CMD_ACT)     &&  dsf;
    wrStb      = accept && (cmd == CMD_WRITE)   && !dsf;
    blockWrStb = accept && (cmd == CMD_WRITE)   &&  dsf;
    refStb     = accept && (cmd == CMD_REFRESH) && !dsf;
    specRefStb = accept && (cmd == CMD_REFRESH) &&  dsf;
    modeSetStb = accept && (cmd == CMD_MODESET) && !dsf;

    busy    = pendColor;
    illegal = pendColor && (cmd != CMD_NOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendColor <= 1'b0;
    else       pendColor <= specLoad && selMask && selColor;
  end

  // R4: busy lasts a single cycle
  p_busy_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  // R4: a dual-select load opens the color data cycle
  p_dual_opens_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !csN && !rasN && !casN && !weN && dsf && selMask && selColor) |=> busy);

  // R8: no command strobe while busy
  p_quiet_when_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(actStb || actWpbStb || wrStb || blockWrStb || refStb || specRefStb || modeSetStb));

  // R7: strobes are mutually exclusive
  p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({actStb, actWpbStb, wrStb, blockWrStb, refStb, specRefStb, modeSetStb}));

endmodule

// File: rtl/gfx_reg_dp.sv
module gfx_reg_dp
  import gfx_smrs_pkg::*;
#(
  parameter int DQ_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  loadStrobe_t     load,
  input  logic [DQ_W-1:0] dq,
  output logic [DQ_W-1:0] maskReg,
  output logic [DQ_W-1:0] colorReg
);

  localparam logic [DQ_W-1:0] ZERO = '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg  <= ZERO;
      colorReg <= ZERO;
    end else begin
      if (load.loadMask)  maskReg  <= dq;
      if (load.loadColor) colorReg <= dq;
    end
  end

  // R2: mask captures the data word on its load edge
  p_mask_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    load.loadMask |=> (maskReg == $past(dq)));

  // R3: color captures the data word on its load edge
  p_color_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    load.loadColor |=> (colorReg == $past(dq)));

  // R9: registers hold without a load strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!load.loadMask && !load.loadColor) |=> ($stable(maskReg) && $stable(colorReg)));

endmodule

// File: rtl/gfx_special_reg_loader.sv
module gfx_special_reg_loader
  import gfx_smrs_pkg::*;
#(
  parameter int DQ_W = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            rasN,
  input  logic            casN,
  input  logic            weN,
  input  logic            dsf,
  input  logic            selMask,
  input  logic            selColor,
  input  logic [DQ_W-1:0] dq,
  output logic [DQ_W-1:0] maskReg,
  output logic [DQ_W-1:0] colorReg,
  output logic            busy,
  output logic            illegal,
  output logic            actStb,
  output logic            actWpbStb,
  output logic            wrStb,
  output logic            blockWrStb,
  output logic            refStb,
  output logic            specRefStb,
  output logic            modeSetStb
);

  loadStrobe_t load;

  gfx_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .csN        (csN),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .dsf        (dsf),
    .selMask    (selMask),
    .selColor   (selColor),
    .load       (load),
    .busy       (busy),
    .illegal    (illegal),
    .actStb     (actStb),
    .actWpbStb  (actWpbStb),
    .wrStb      (wrStb),
    .blockWrStb (blockWrStb),
    .refStb     (refStb),
    .specRefStb (specRefStb),
    .modeSetStb (modeSetStb)
  );

  gfx_reg_dp #(.DQ_W(DQ_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .load     (load),
    .dq       (dq),
    .maskReg  (maskReg),
    .colorReg (colorReg)
  );

endmodule

// File: tb/tb_gfx_special_reg_loader.sv
`timescale 1ns/1ps
module tb_gfx_special_reg_loader;

  localparam int DQ_W = 32;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic            dsf = 1'b0, selMask = 1'b0, selColor = 1'b0;
  logic [DQ_W-1:0] dq = '0;
  logic [DQ_W-1:0] maskReg, colorReg;
  logic busy, illegal, actStb, actWpbStb, wrStb, blockWrStb, refStb, specRefStb, modeSetStb;

  int checks = 0;
  int fails  = 0;
  logic [DQ_W-1:0] mMask = '0, mColor = '0;
  logic            mPend = 1'b0;

  always #2.5 clk = ~clk;

  gfx_special_reg_loader #(.DQ_W(DQ_W)) dut (.*);

  task automatic chk(input logic ok, input string what, input logic [DQ_W-1:0] act, input logic [DQ_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [6:0] expStrobes(input logic c, input logic r, input logic a,
                                            input logic w, input logic d, input logic pend);
    logic isAct, isWr, isRef, isMrs, g;
    isAct = !c && !r &&  a &&  w;
    isWr  = !c &&  r && !a && !w;
    isRef = !c && !r && !a &&  w;
    isMrs = !c && !r && !a && !w;
    g = !pend;
    return {isAct && !d && g, isAct && d && g, isWr && !d && g, isWr && d && g,
            isRef && !d && g, isRef && d && g, isMrs && !d && g};
  endfunction

  task automatic step(input logic c, input logic r, input logic a, input logic w,
                      input logic d, input logic s5, input logic s6, input logic [DQ_W-1:0] v);
    logic [6:0] eS, aS;
    logic isNop, isMrs;
    @(negedge clk);
    csN = c; rasN = r; casN = a; weN = w; dsf = d; selMask = s5; selColor = s6; dq = v;
    #1;
    isNop = c || (r && a && w);
    isMrs = !c && !r && !a && !w;
    eS = expStrobes(c, r, a, w, d, mPend);
    aS = {actStb, actWpbStb, wrStb, blockWrStb, refStb, specRefStb, modeSetStb};
    chk(aS == eS, "R5 R6 R7 R8 strobes", DQ_W'(aS), DQ_W'(eS));
    chk(busy == mPend, "R4 busy", DQ_W'(busy), DQ_W'(mPend));
    chk(illegal == (mPend && !isNop), "R8 illegal", DQ_W'(illegal), DQ_W'(mPend && !isNop));
    if (mPend) begin
      mColor = v; mPend = 1'b0;
    end else if (isMrs && d) begin
      if (s5) mMask = v;
      if (s6 && !s5) mColor = v;
      if (s5 && s6) mPend = 1'b1;
    end
    @(posedge clk); #1;
    chk(maskReg == mMask, "R2 R4 R9 mask", maskReg, mMask);
    chk(colorReg == mColor, "R3 R4 R9 color", colorReg, mColor);
  endtask

  task automatic nop();
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(maskReg == '0, "R1 mask reset", maskReg, '0);
    chk(colorReg == '0, "R1 color reset", colorReg, '0);
    chk(busy == 1'b0, "R1 busy reset", DQ_W'(busy), '0);
    @(negedge clk); rstN = 1'b1;

    // R2 mask only
    step(0,0,0,0, 1, 1, 0, 32'hA5A5_0F0F);
    // R3 color only
    step(0,0,0,0, 1, 0, 1, 32'h1234_5678);
    // R4 combined: mask then color, command ignored in busy cycle (R8)
    step(0,0,0,0, 1, 1, 1, 32'hFFFF_FFFF);
    step(0,0,0,0, 1, 0, 1, 32'h0000_0000);
    // R8: command right after completion accepted
    step(0,0,1,1, 1, 0, 0, '0);
    // back-to-back combined loads, second one lands in busy (R8)
    step(0,0,0,0, 1, 1, 1, 32'hDEAD_BEEF);
    step(0,0,0,0, 1, 1, 1, 32'hCAFE_F00D);
    step(0,0,0,0, 1, 1, 0, 32'h0BAD_0001);
    // R5 normal mode set leaves registers
    step(0,0,0,0, 0, 1, 1, 32'h5555_5555);
    // R9 special load with no select
    step(0,0,0,0, 1, 0, 0, 32'h7777_7777);
    // R6 / R7 strobe encodings
    step(0,0,1,1, 1, 0, 0, '0);
    step(0,1,0,0, 1, 0, 0, '0);
    step(0,0,0,1, 1, 0, 0, '0);
    step(0,0,1,1, 0, 0, 0, '0);
    step(0,1,0,0, 0, 0, 0, '0);
    step(0,0,0,1, 0, 0, 0, '0);
    // R8 busy cycle with deselect is not illegal
    step(0,0,0,0, 1, 1, 1, 32'h0F0F_F0F0);
    step(1,0,0,0, 1, 0, 0, 32'h3C3C_C3C3);
    nop();

    for (int i = 0; i < 600; i++) begin
      logic [3:0] cmdBits;
      logic c;
      cmdBits = 4'($urandom_range(0, 15));
      c = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 2) == 0) cmdBits = 4'b0000;
      step(c, cmdBits[2], cmdBits[1], cmdBits[0], 1'($urandom), 1'($urandom), 1'($urandom), $urandom);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule